// File: doc/BRIEF.md
# Processor Register File with Fixed and Special-Purpose Registers

This block is the register storage of a small 16-bit processor core. One 4-bit register address space covers sixteen entries. Addresses 8 to 15 are eight general-purpose 16-bit registers, named ra to rh, with ra at address 8. Addresses 0 to 7 are special entries:

| Address | Entry |
|---|---|
| 0, 1, 2 | Hard-wired constants |
| 3 | Shift-amount register, 4 bits wide |
| 4 | Next-PC holder |
| 5 | Status flags |
| 6 | Parallel-input latch |
| 7 | Return-address (link) register |

The core decodes an instruction and drives the block's control inputs. Two combinational read ports supply the operands, and one write port takes the result. Dedicated inputs serve four further purposes:
- capture the next PC on every clock;
- load the flags;
- sample the parallel input on every clock;
- copy the next PC into the link register on a call.

A separate immediate-load path puts a sign-extended 15-bit constant into ra. The read ports observe the state as it will be after the current edge. A value written in a cycle is therefore visible on a read of the same address in that same cycle.

Top module: `sprf_regfile`

## Requirements
- R1: After reset all storage is zero. Address 1 then reads 0xFFFF, address 2 reads 0x8000, and every other address reads 0x0000.
- R2: Address 0 always reads 0x0000, address 1 always reads 0xFFFF and address 2 always reads 0x8000. Port writes to these addresses have no effect.
- R3: A port write to address 3 keeps only wr_data[3:0]. A read of address 3 returns those 4 bits in [3:0] and zeros in [15:4].
- R4: Addresses 4 and 6 always read 0x0000, and port writes to them are ignored. Each clock edge captures npc_in into the next-PC holder and pio_in into the parallel-input latch. The latch is visible on pio_q from that edge on.
- R5: When flag_en is high, flag_in is loaded into the flag register on the clock edge. The bit layout is bit 0 carry, bit 1 zero, bit 2 overflow and bit 3 sign. Address 5 reads the flags in bits [3:0] and zeros in [15:4]. Port writes to address 5 are ignored.
- R6: When link_en is high, the clock edge loads address 7 with the next-PC value captured at the previous edge. Port writes to address 7 also store all 16 bits. When both happen in the same cycle, link_en wins.
- R7: When ml_en is high, ra (address 8) is loaded with {ml_imm[14], ml_imm[14:0]}. This load takes priority over a port write to address 8 in the same cycle.
- R8: Addresses 8 to 15 store all 16 bits of a port write independently of one another.
- R9: Any update that the coming edge will perform is already visible on a read of the affected address in the same cycle. This covers port writes, flag loads, link loads and immediate loads.
- R10: The two read ports decode their addresses independently and may read the same or different addresses in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_addr | input | 4 | Read port A address |
| rd_a_data | output | 16 | Read port A data |
| rd_b_addr | input | 4 | Read port B address |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Port write enable |
| wr_addr | input | 4 | Port write address |
| wr_data | input | 16 | Port write data |
| ml_en | input | 1 | Immediate load into ra |
| ml_imm | input | 15 | Immediate value for ra |
| npc_in | input | 16 | Next-PC value, captured every clock |
| flag_en | input | 1 | Flag load enable |
| flag_in | input | 4 | New flags: carry, zero, overflow, sign |
| link_en | input | 1 | Copy the held next PC into the link register |
| pio_in | input | 16 | Parallel input, sampled every clock |
| pio_q | output | 16 | Sampled parallel input |

## Verification
The bench targets writes aimed at the constant, inaccessible and flag addresses. A design that decodes these writes loosely would let such a write change a value that must stay fixed or hidden. Bit 14 of the immediate is toggled, and the immediate load is made to collide with a port write to ra. Wrong sign extension or wrong priority would leave ra with the wrong top bit or with the port data. Link loads are timed against a changing npc_in, so a link register that took the live next-PC value instead of the held one would be off by one instruction. Reads of the address being written in the same cycle expose a missing bypass as a stale value. Writes to address 3 carry upper data bits, which catches a shift register that keeps more than four bits.

// File: rtl/sprf_pkg.sv
package sprf_pkg;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int NGPR  = 8;
    localparam int GIW   = $clog2(NGPR);
    localparam int SHW   = 4;
    localparam int FLW   = 4;
    localparam int IMMW  = DW - 1;
    localparam int NRD   = 2;

    typedef logic [AW-1:0] rf_addr_t;
    typedef logic [DW-1:0] rf_word_t;

    localparam rf_addr_t AD_ZERO  = rf_addr_t'(0);
    localparam rf_addr_t AD_ONES  = rf_addr_t'(1);
    localparam rf_addr_t AD_MSB   = rf_addr_t'(2);
    localparam rf_addr_t AD_SHIFT = rf_addr_t'(3);
    localparam rf_addr_t AD_NPC   = rf_addr_t'(4);
    localparam rf_addr_t AD_FLAGS = rf_addr_t'(5);
    localparam rf_addr_t AD_PIO   = rf_addr_t'(6);
    localparam rf_addr_t AD_LINK  = rf_addr_t'(7);
    localparam rf_addr_t AD_RA    = rf_addr_t'(NGPR);

    typedef struct packed {
        logic [NGPR-1:0][DW-1:0] gpr;
        logic [SHW-1:0]          sh;
        logic [DW-1:0]           npc;
        logic [FLW-1:0]          flg;
        logic [DW-1:0]           pio;
        logic [DW-1:0]           link;
    } rf_state_t;
endpackage

// File: rtl/sprf_next.sv
module sprf_next
    import sprf_pkg::*;
(
    input  rf_state_t         state_q,
    input  logic              wr_en,
    input  rf_addr_t          wr_addr,
    input  rf_word_t          wr_data,
    input  logic              ml_en,
    input  logic [IMMW-1:0]   ml_imm,
    input  rf_word_t          npc_in,
    input  logic              flag_en,
    input  logic [FLW-1:0]    flag_in,
    input  logic              link_en,
    input  rf_word_t          pio_in,
    output rf_state_t         state_d
);
    always_comb begin
        state_d     = state_q;
        state_d.npc = npc_in;
        state_d.pio = pio_in;
        if (flag_en) begin
            state_d.flg = flag_in;
        end
        if (wr_en) begin
            if (wr_addr[AW-1]) begin
                state_d.gpr[wr_addr[GIW-1:0]] = wr_data;
            end else begin
                case (wr_addr)
                    AD_SHIFT: state_d.sh   = wr_data[SHW-1:0];
                    AD_LINK:  state_d.link = wr_data;
                    default:  ;
                endcase
            end
        end
        // Immediate load outranks the port write to ra (R7)
        if (ml_en) begin
            state_d.gpr[0] = {ml_imm[IMMW-1], ml_imm};
        end
        // Link load outranks the port write to r7 (R6)
        if (link_en) begin
            state_d.link = state_q.npc;
        end
    end
endmodule

// File: rtl/sprf_rdmux.sv
module sprf_rdmux
    import sprf_pkg::*;
(
    input  rf_state_t st,
    input  rf_addr_t  addr,
    output rf_word_t  data
);
    always_comb begin
        data = '0;
        if (addr[AW-1]) begin
            data = st.gpr[addr[GIW-1:0]];
        end else begin
            case (addr)
                AD_ONES:  data = '1;
                AD_MSB:   data = {1'b1, {(DW-1){1'b0}}};
                AD_SHIFT: data = {{(DW-SHW){1'b0}}, st.sh};
                AD_FLAGS: data = {{(DW-FLW){1'b0}}, st.flg};
                AD_LINK:  data = st.link;
                default:  data = '0;
            endcase
        end
    end
endmodule

// File: rtl/sprf_regfile.sv
module sprf_regfile
    import sprf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      rd_a_addr,
    output logic [15:0]     rd_a_data,
    input  logic [3:0]      rd_b_addr,
    output logic [15:0]     rd_b_data,
    input  logic            wr_en,
    input  logic [3:0]      wr_addr,
    input  logic [15:0]     wr_data,
    input  logic            ml_en,
    input  logic [14:0]     ml_imm,
    input  logic [15:0]     npc_in,
    input  logic            flag_en,
    input  logic [3:0]      flag_in,
    input  logic            link_en,
    input  logic [15:0]     pio_in,
    output logic [15:0]     pio_q
);
    rf_state_t state_q, state_d;
    rf_addr_t  rd_addr [NRD];
    rf_word_t  rd_data [NRD];

    sprf_next i_next (
        .state_q (state_q),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ml_en   (ml_en),
        .ml_imm  (ml_imm),
        .npc_in  (npc_in),
        .flag_en (flag_en),
        .flag_in (flag_in),
        .link_en (link_en),
        .pio_in  (pio_in),
        .state_d (state_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;

    // Reads see the post-edge state: write-first bypass (R9)
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        sprf_rdmux i_rdmux (
            .st   (state_d),
            .addr (rd_addr[g]),
            .data (rd_data[g])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign pio_q     = state_q.pio;

    a_r2_ones_const: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == 4'd1) |-> (rd_b_data == 16'hFFFF));
    a_r3_shift_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == 4'd3) |-> (rd_a_data[15:4] == 12'd0));
    a_r4_hidden_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == 4'd4 || rd_a_addr == 4'd6) |-> (rd_a_data == 16'd0));
    a_r5_flags_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == 4'd5) |-> (rd_b_data[15:4] == 12'd0));
    a_r6_link_held_npc: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_en) && !link_en && rd_a_addr == 4'd7
         && !(wr_en && wr_addr == 4'd7)) |-> (rd_a_data == $past(state_q.npc)));
    a_r7_movelong_sext: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ml_en) && !ml_en && rd_b_addr == 4'd8
         && !(wr_en && wr_addr == 4'd8)) |-> (rd_b_data == {$past(ml_imm[14]), $past(ml_imm)}));
    a_r9_bypass_gpr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[3] && rd_a_addr == wr_addr && !(ml_en && wr_addr == 4'd8))
        |-> (rd_a_data == wr_data));
    a_r4_pio_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pio_q == $past(pio_in)));
endmodule

// File: tb/test_sprf_regfile.sv
module test_sprf_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [15:0] rd_a_data, rd_b_data, wr_data = '0, npc_in = '0, pio_in = '0, pio_q;
    logic        wr_en = 1'b0, ml_en = 1'b0, flag_en = 1'b0, link_en = 1'b0;
    logic [14:0] ml_imm = '0;
    logic [3:0]  flag_in = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference state: m_* current, n_* after the coming edge
    logic [15:0] m_gpr [8];
    logic [15:0] n_gpr [8];
    logic [3:0]  m_sh, n_sh, m_flg, n_flg;
    logic [15:0] m_npc, n_npc, m_link, n_link, m_pio, n_pio;

    always #5 clk = ~clk;

    sprf_regfile i_sprf_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ml_en(ml_en), .ml_imm(ml_imm), .npc_in(npc_in),
        .flag_en(flag_en), .flag_in(flag_in), .link_en(link_en),
        .pio_in(pio_in), .pio_q(pio_q)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_gpr[i] = '0;
        m_sh = '0; m_flg = '0; m_npc = '0; m_link = '0; m_pio = '0;
    endtask

    task automatic model_next();
        for (int i = 0; i < 8; i++) n_gpr[i] = m_gpr[i];
        n_sh = m_sh; n_flg = m_flg; n_link = m_link;
        n_npc = npc_in; n_pio = pio_in;
        if (wr_en) begin
            if (wr_addr >= 4'd8)      n_gpr[wr_addr - 4'd8] = wr_data;
            else if (wr_addr == 4'd3) n_sh = wr_data[3:0];
            else if (wr_addr == 4'd7) n_link = wr_data;
        end
        if (flag_en) n_flg = flag_in;
        if (ml_en)   n_gpr[0] = {ml_imm[14], ml_imm};
        if (link_en) n_link = m_npc;
    endtask

    function automatic logic [15:0] expect_rd(input logic [3:0] a);
        if (a >= 4'd8) return n_gpr[a - 4'd8];
        case (a)
            4'd1: return 16'hFFFF;
            4'd2: return 16'h8000;
            4'd3: return {12'd0, n_sh};
            4'd5: return {12'd0, n_flg};
            4'd7: return n_link;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] a);
        if (wr_en && wr_addr == a && (a == 4'd3 || a == 4'd7 || a >= 4'd8)) return "R9";
        if ((flag_en && a == 4'd5) || (link_en && a == 4'd7) || (ml_en && a == 4'd8)) return "R9";
        if (a <= 4'd2) return "R2";
        if (a == 4'd3) return "R3";
        if (a == 4'd4 || a == 4'd6) return "R4";
        if (a == 4'd5) return "R5";
        if (a == 4'd7) return "R6";
        if (a == 4'd8) return "R7";
        return "R8";
    endfunction

    // inputs already driven; compare at mid-low phase, then take the edge
    task automatic step();
        model_next();
        #2;
        check(tag(rd_a_addr), "port A", rd_a_data, expect_rd(rd_a_addr));
        check((rd_a_addr != rd_b_addr) ? "R10" : tag(rd_b_addr), "port B",
              rd_b_data, expect_rd(rd_b_addr));
        check("R4", "pio_q", pio_q, m_pio);
        @(posedge clk);
        for (int i = 0; i < 8; i++) m_gpr[i] = n_gpr[i];
        m_sh = n_sh; m_flg = n_flg; m_npc = n_npc; m_link = n_link; m_pio = n_pio;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; ml_en = 1'b0; flag_en = 1'b0; link_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d,
                      input logic [3:0] ra, input logic [3:0] rb);
        idle();
        wr_en = 1'b1; wr_addr = a; wr_data = d; rd_a_addr = ra; rd_b_addr = rb;
        step();
    endtask

    task automatic rd(input logic [3:0] ra, input logic [3:0] rb);
        idle();
        rd_a_addr = ra; rd_b_addr = rb;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every address, before any edge changes it
        for (int a = 0; a < 16; a++) begin
            rd_a_addr = 4'(a); rd_b_addr = 4'(15 - a);
            #1;
            model_next();
            check("R1", "reset A", rd_a_data, expect_rd(4'(a)));
            check("R1", "reset B", rd_b_data, expect_rd(4'(15 - a)));
        end
        // R2/R4/R5: writes to fixed, hidden and flag addresses
        wr(4'd0, 16'h1234, 4'd0, 4'd1);
        wr(4'd1, 16'h0000, 4'd1, 4'd2);
        wr(4'd2, 16'h5555, 4'd2, 4'd0);
        wr(4'd4, 16'hBEEF, 4'd4, 4'd6);
        wr(4'd6, 16'hCAFE, 4'd6, 4'd4);
        wr(4'd5, 16'hFFFF, 4'd5, 4'd5);
        rd(4'd5, 4'd4);
        // R3: only four bits kept, bypass on same cycle
        wr(4'd3, 16'hFFF9, 4'd3, 4'd3);
        rd(4'd3, 4'd0);
        // R5: flag load with bypass, then held
        idle(); flag_en = 1'b1; flag_in = 4'b1010; rd_a_addr = 4'd5; rd_b_addr = 4'd3; step();
        rd(4'd5, 4'd5);
        // R6: link takes the next PC held from the previous edge
        idle(); npc_in = 16'h0101; rd_a_addr = 4'd7; step();
        idle(); npc_in = 16'h0202; link_en = 1'b1; rd_a_addr = 4'd7; rd_b_addr = 4'd7; step();
        rd(4'd7, 4'd4);
        idle(); npc_in = 16'h0303; link_en = 1'b1; wr_en = 1'b1; wr_addr = 4'd7;
        wr_data = 16'h7777; rd_a_addr = 4'd7; step();
        wr(4'd7, 16'hA5A5, 4'd7, 4'd7);
        // R7: sign extension both ways, priority over port write
        idle(); ml_en = 1'b1; ml_imm = 15'h4001; rd_a_addr = 4'd8; rd_b_addr = 4'd8; step();
        rd(4'd8, 4'd9);
        idle(); ml_en = 1'b1; ml_imm = 15'h3FFE; wr_en = 1'b1; wr_addr = 4'd8;
        wr_data = 16'h1111; rd_a_addr = 4'd8; rd_b_addr = 4'd8; step();
        rd(4'd8, 4'd0);
        // R8: each general register independent
        for (int r = 8; r < 16; r++) wr(4'(r), 16'(16'h1000 * r + r), 4'(r), 4'(23 - r));
        for (int r = 8; r < 16; r++) rd(4'(r), 4'(r ^ 1));
        // random mix with pio and npc toggling
        for (int c = 0; c < 600; c++) begin
            idle();
            wr_en   = ($urandom_range(0, 3) != 0);
            wr_addr = 4'($urandom_range(0, 15));
            wr_data = 16'($urandom);
            ml_en   = ($urandom_range(0, 4) == 0);
            ml_imm  = 15'($urandom);
            flag_en = ($urandom_range(0, 3) == 0);
            flag_in = 4'($urandom);
            link_en = ($urandom_range(0, 5) == 0);
            npc_in  = 16'($urandom);
            pio_in  = 16'($urandom);
            rd_a_addr = ($urandom_range(0, 2) == 0) ? wr_addr : 4'($urandom_range(0, 15));
            rd_b_addr = 4'($urandom_range(0, 15));
            step();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule